// File: doc/BRIEF.md
# Interrupt Flag Control Unit

This block holds the maskable-interrupt enable state of a small processor core and updates it as set-interrupt and clear-interrupt instructions retire. With each retire strobe it receives an opcode class and the current machine mode: protection on or off, virtual-8086 mode, current and I/O privilege levels, the two virtual-interrupt extension enables, the virtual interrupt pending bit and a lock-prefix indicator. For a set instruction it chooses one of four outcomes. It can set the real interrupt flag, set the virtual interrupt flag, report a general-protection fault, or report an undefined-opcode fault.

Setting the real flag from a cleared state arms a one-instruction shadow. While the shadow is armed, both maskable and non-maskable requests are held off. The block combines its flag and shadow state with incoming interrupt requests to produce accept signals, which the core's interrupt sequencer uses. Decode, fault delivery and the interrupt controller are handled elsewhere.

Top module: `intflag_ctrl`

## Requirements
- R1: With `prot_en`=0, a retired set instruction (`op_class`=2'b01) without lock sets `if_flag` to 1 at the next clock edge.
- R2: With `prot_en`=1 and `v86_mode`=0, a set instruction sets `if_flag` when `iopl` >= `cpl`.
- R3: With `prot_en`=1, `v86_mode`=0 and `iopl` < `cpl`, a set instruction sets `vif_flag` only when `cpl`=3 and `pvi_en`=1. Otherwise `gp_fault` is raised and neither flag changes.
- R4: With `prot_en`=1 and `v86_mode`=1, a set instruction sets `if_flag` when `iopl`=3.
- R5: With `prot_en`=1, `v86_mode`=1 and `iopl` < 3, a set instruction sets `vif_flag` only when `vip`=0 and `vme_en`=1. Otherwise `gp_fault` is raised and neither flag changes.
- R6: A set instruction that sets `vif_flag` leaves `if_flag` unchanged.
- R7: A set instruction with `lock_pfx`=1 raises `ud_fault` in every mode and leaves both flags unchanged.
- R8: A set instruction that changes `if_flag` from 0 to 1 arms `shadow_active`. While it is armed, `intr_accept` stays 0. It clears when the next instruction retires, and `intr_accept` = `intr_req` & `if_flag` & !`shadow_active` at all times.
- R9: A set instruction retired while `if_flag` is already 1 does not arm the shadow, so a second back-to-back set ends the shadow.
- R10: A retired clear instruction (`op_class`=2'b10) sets `if_flag` to 0 and clears the shadow, which cancels a pending enable. Classes 2'b00 and 2'b11 change no flag.
- R11: `nmi_accept` = `nmi_req` & !`shadow_active`, so a non-maskable request is held off only while the shadow is armed.
- R12: While `rst` is high and on the first cycle after it, `if_flag`, `vif_flag`, `shadow_active`, `gp_fault` and `ud_fault` are all 0.
- R13: `gp_fault` and `ud_fault` are one-cycle pulses visible in the cycle after the faulting retire, they are never high together, and a fault leaves the shadow clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| op_class | input | 2 | 00 other, 01 set-interrupt, 10 clear-interrupt, 11 other |
| lock_pfx | input | 1 | Retiring instruction carries a lock prefix |
| prot_en | input | 1 | Protection enabled |
| v86_mode | input | 1 | Virtual-8086 mode active |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| pvi_en | input | 1 | Protected-mode virtual interrupts enabled |
| vme_en | input | 1 | Virtual-8086 mode extensions enabled |
| vip | input | 1 | Virtual interrupt pending |
| intr_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| if_flag | output | 1 | Real interrupt flag |
| vif_flag | output | 1 | Virtual interrupt flag |
| gp_fault | output | 1 | General-protection fault pulse |
| ud_fault | output | 1 | Undefined-opcode fault pulse |
| shadow_active | output | 1 | One-instruction interrupt shadow armed |
| intr_accept | output | 1 | Maskable interrupt accepted |
| nmi_accept | output | 1 | Non-maskable interrupt accepted |

## Verification
Two events can fall in the same cycle: a pending interrupt request and the retire that either arms the shadow or ends it. The bench keeps `intr_req` and `nmi_req` high through a set instruction, an idle cycle and the following retire, and also retires set, set and set, clear back to back. Each cycle, a behavioural model predicts the flags, the shadow and both accept outputs, and the bench compares these against the design at mid-cycle. A long constrained-random stream then mixes every mode, privilege pair and opcode class with random requests.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    parameter int PRIV_W = 2;
    localparam int OPC_W = 2;

    typedef logic [PRIV_W-1:0] priv_t;

    localparam priv_t PRIV_LEAST = '1;

    typedef enum logic [OPC_W-1:0] {
        OPC_OTHER = 2'b00,
        OPC_SET   = 2'b01,
        OPC_CLEAR = 2'b10,
        OPC_RSVD  = 2'b11
    } opc_e;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_REAL,
        RES_VIRT,
        RES_GPF,
        RES_UDF
    } res_e;

    typedef struct packed {
        logic  prot_en;
        logic  v86;
        priv_t cpl;
        priv_t iopl;
        logic  pvi_en;
        logic  vme_en;
        logic  vip;
        logic  lock;
    } mode_t;

    // Outcome of a set-interrupt instruction for a given machine mode.
    function automatic res_e set_outcome(input mode_t m);
        res_e r;
        if (m.lock)
            r = RES_UDF;
        else if (!m.prot_en)
            r = RES_REAL;
        else if (!m.v86) begin
            if (m.iopl >= m.cpl)
                r = RES_REAL;
            else if ((m.cpl == PRIV_LEAST) && m.pvi_en)
                r = RES_VIRT;
            else
                r = RES_GPF;
        end else begin
            if (m.iopl == PRIV_LEAST)
                r = RES_REAL;
            else if (!m.vip && m.vme_en)
                r = RES_VIRT;
            else
                r = RES_GPF;
        end
        return r;
    endfunction

endpackage

// File: rtl/ifc_decide.sv
module ifc_decide
    import ifc_pkg::*;
(
    input  logic                  retire,
    input  logic [OPC_W-1:0]      opc_raw,
    input  mode_t                 mode,
    output logic                  is_set,
    output logic                  is_clear,
    output res_e                  res
);

    opc_e opc;

    always_comb begin
        opc      = opc_e'(opc_raw);
        is_set   = retire && (opc == OPC_SET);
        is_clear = retire && (opc == OPC_CLEAR);
        res      = is_set ? set_outcome(mode) : RES_NONE;
    end

endmodule

// File: rtl/ifc_flags.sv
module ifc_flags
    import ifc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic is_set,
    input  logic is_clear,
    input  res_e res,
    output logic if_q,
    output logic vif_q,
    output logic gp_q,
    output logic ud_q,
    output logic arm,
    output logic fault_now
);

    logic if_d, vif_d;

    always_comb begin
        if_d      = if_q;
        vif_d     = vif_q;
        arm       = 1'b0;
        fault_now = (res == RES_GPF) || (res == RES_UDF);
        if (is_clear) begin
            if_d = 1'b0;
        end else if (is_set) begin
            unique case (res)
                RES_REAL: begin
                    if_d = 1'b1;
                    arm  = !if_q;
                end
                RES_VIRT: vif_d = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if_q  <= 1'b0;
            vif_q <= 1'b0;
            gp_q  <= 1'b0;
            ud_q  <= 1'b0;
        end else begin
            if_q  <= if_d;
            vif_q <= vif_d;
            gp_q  <= (res == RES_GPF);
            ud_q  <= (res == RES_UDF);
        end
    end

endmodule

// File: rtl/ifc_shadow.sv
module ifc_shadow (
    input  logic clk,
    input  logic rst,
    input  logic retire,
    input  logic arm,
    input  logic fault_now,
    input  logic if_q,
    input  logic intr_req,
    input  logic nmi_req,
    output logic shadow_q,
    output logic intr_acc,
    output logic nmi_acc
);

    logic shadow_d;

    always_comb begin
        shadow_d = shadow_q;
        if (fault_now)
            shadow_d = 1'b0;
        else if (retire)
            shadow_d = arm;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= 1'b0;
        else
            shadow_q <= shadow_d;
    end

    assign intr_acc = intr_req && if_q && !shadow_q;
    assign nmi_acc  = nmi_req && !shadow_q;

endmodule

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
    import ifc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              retire_valid,
    input  logic [1:0]        op_class,
    input  logic              lock_pfx,
    input  logic              prot_en,
    input  logic              v86_mode,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    input  logic              pvi_en,
    input  logic              vme_en,
    input  logic              vip,
    input  logic              intr_req,
    input  logic              nmi_req,
    output logic              if_flag,
    output logic              vif_flag,
    output logic              gp_fault,
    output logic              ud_fault,
    output logic              shadow_active,
    output logic              intr_accept,
    output logic              nmi_accept
);

    mode_t mode;
    logic  is_set, is_clear, arm, fault_now;
    res_e  res;

    always_comb begin
        mode.prot_en = prot_en;
        mode.v86     = v86_mode;
        mode.cpl     = cpl;
        mode.iopl    = iopl;
        mode.pvi_en  = pvi_en;
        mode.vme_en  = vme_en;
        mode.vip     = vip;
        mode.lock    = lock_pfx;
    end

    ifc_decide u_decide (
        .retire   (retire_valid),
        .opc_raw  (op_class),
        .mode     (mode),
        .is_set   (is_set),
        .is_clear (is_clear),
        .res      (res)
    );

    ifc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .is_set    (is_set),
        .is_clear  (is_clear),
        .res       (res),
        .if_q      (if_flag),
        .vif_q     (vif_flag),
        .gp_q      (gp_fault),
        .ud_q      (ud_fault),
        .arm       (arm),
        .fault_now (fault_now)
    );

    ifc_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .retire    (retire_valid),
        .arm       (arm),
        .fault_now (fault_now),
        .if_q      (if_flag),
        .intr_req  (intr_req),
        .nmi_req   (nmi_req),
        .shadow_q  (shadow_active),
        .intr_acc  (intr_accept),
        .nmi_acc   (nmi_accept)
    );

endmodule

// File: rtl/intflag_ctrl_chk.sv
module intflag_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       retire_valid,
    input logic [1:0] op_class,
    input logic       lock_pfx,
    input logic       prot_en,
    input logic       v86_mode,
    input logic [1:0] cpl,
    input logic [1:0] iopl,
    input logic       pvi_en,
    input logic       vme_en,
    input logic       vip,
    input logic       intr_req,
    input logic       nmi_req,
    input logic       if_flag,
    input logic       vif_flag,
    input logic       gp_fault,
    input logic       ud_fault,
    input logic       shadow_active,
    input logic       intr_accept,
    input logic       nmi_accept
);

    logic set_now;
    assign set_now = retire_valid && (op_class == 2'b01);

    p_real_mode_sets_r1: assert property (@(posedge clk) disable iff (rst)
        set_now && !lock_pfx && !prot_en |=> if_flag);

    p_gp_keeps_flags_r3: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> $stable(if_flag) && $stable(vif_flag));

    p_virt_keeps_if_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(vif_flag) |-> $stable(if_flag));

    p_lock_undef_r7: assert property (@(posedge clk) disable iff (rst)
        set_now && lock_pfx |=> ud_fault && $stable(if_flag) && $stable(vif_flag));

    p_shadow_blocks_intr_r8: assert property (@(posedge clk) disable iff (rst)
        shadow_active |-> !intr_accept);

    p_shadow_one_retire_r8: assert property (@(posedge clk) disable iff (rst)
        shadow_active && retire_valid |=> !shadow_active);

    p_shadow_needs_if_r9: assert property (@(posedge clk) disable iff (rst)
        shadow_active |-> if_flag);

    p_clear_drops_if_r10: assert property (@(posedge clk) disable iff (rst)
        retire_valid && (op_class == 2'b10) |=> !if_flag && !shadow_active);

    p_nmi_gate_r11: assert property (@(posedge clk) disable iff (rst)
        nmi_req && !shadow_active |-> nmi_accept);

    p_nmi_held_r11: assert property (@(posedge clk) disable iff (rst)
        shadow_active |-> !nmi_accept);

    p_reset_clear_r12: assert property (@(posedge clk)
        $past(rst) |-> !if_flag && !vif_flag && !shadow_active && !gp_fault && !ud_fault);

    p_fault_exclusive_r13: assert property (@(posedge clk) disable iff (rst)
        !(gp_fault && ud_fault));

    p_fault_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        (gp_fault || ud_fault) |-> !shadow_active);

endmodule

bind intflag_ctrl intflag_ctrl_chk u_chk (.*);

// File: tb/tb_intflag_ctrl.sv
module tb_intflag_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       retire_valid;
    logic [1:0] op_class;
    logic       lock_pfx, prot_en, v86_mode;
    logic [1:0] cpl, iopl;
    logic       pvi_en, vme_en, vip, intr_req, nmi_req;
    logic       if_flag, vif_flag, gp_fault, ud_fault, shadow_active, intr_accept, nmi_accept;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R12";

    // Reference state
    bit m_if, m_vif, m_sh, m_gp, m_ud;

    always #2 clk = ~clk;

    intflag_ctrl dut (.*);

    task automatic check1(input string what, input logic act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit arm;
        if (rst) begin
            m_if = 0; m_vif = 0; m_sh = 0; m_gp = 0; m_ud = 0;
            return;
        end
        m_gp = 0; m_ud = 0; arm = 0;
        if (retire_valid && op_class == 2'b01) begin
            if (lock_pfx) m_ud = 1;
            else if (!prot_en) begin arm = !m_if; m_if = 1; end
            else if (!v86_mode) begin
                if (iopl >= cpl) begin arm = !m_if; m_if = 1; end
                else if (cpl == 3 && pvi_en) m_vif = 1;
                else m_gp = 1;
            end else begin
                if (iopl == 3) begin arm = !m_if; m_if = 1; end
                else if (!vip && vme_en) m_vif = 1;
                else m_gp = 1;
            end
        end else if (retire_valid && op_class == 2'b10) begin
            m_if = 0;
        end
        if (retire_valid) m_sh = arm;
    endtask

    // Advance one clock; model and compare at mid-cycle with held inputs.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
        check1("if_flag", if_flag, m_if);
        check1("vif_flag", vif_flag, m_vif);
        check1("gp_fault", gp_fault, m_gp);
        check1("ud_fault", ud_fault, m_ud);
        check1("shadow_active", shadow_active, m_sh);
        check1("intr_accept", intr_accept, intr_req && m_if && !m_sh);
        check1("nmi_accept", nmi_accept, nmi_req && !m_sh);
    endtask

    task automatic drive(input bit rv, input logic [1:0] op, input bit lk, input bit pe,
                         input bit vm, input logic [1:0] c, input logic [1:0] io,
                         input bit pv, input bit vm_e, input bit vp);
        retire_valid = rv; op_class = op; lock_pfx = lk; prot_en = pe; v86_mode = vm;
        cpl = c; iopl = io; pvi_en = pv; vme_en = vm_e; vip = vp;
        tick();
    endtask

    task automatic idle();
        drive(0, 2'b00, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        idle();
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; intr_req = 1'b0; nmi_req = 1'b0;
        tag = "R12";
        do_reset();

        tag = "R1";  // real mode, with requests pending across the set
        intr_req = 1; nmi_req = 1;
        drive(1, 2'b01, 0, 0, 0, 2'd3, 2'd0, 0, 0, 0);
        tag = "R8";  // shadow holds through an idle cycle
        idle();
        drive(1, 2'b00, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        idle();

        tag = "R10"; // clear right after set cancels enable
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b11, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        idle();

        tag = "R9";  // set, set, set
        drive(1, 2'b01, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);

        tag = "R2";
        drive(1, 2'b01, 0, 1, 0, 2'd1, 2'd2, 0, 0, 0);
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b01, 0, 1, 0, 2'd2, 2'd2, 0, 0, 0);
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);

        tag = "R3";
        drive(1, 2'b01, 0, 1, 0, 2'd2, 2'd1, 1, 1, 0);
        drive(1, 2'b01, 0, 1, 0, 2'd3, 2'd0, 0, 1, 0);
        tag = "R6";
        drive(1, 2'b01, 0, 1, 0, 2'd3, 2'd0, 1, 0, 0);
        idle();

        do_reset();
        tag = "R4";
        drive(1, 2'b01, 0, 1, 1, 2'd3, 2'd3, 0, 0, 1);
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        tag = "R5";
        drive(1, 2'b01, 0, 1, 1, 2'd3, 2'd2, 0, 1, 1);
        drive(1, 2'b01, 0, 1, 1, 2'd3, 2'd2, 0, 0, 0);
        drive(1, 2'b01, 0, 1, 1, 2'd3, 2'd1, 0, 1, 0);
        idle();

        do_reset();
        tag = "R7";
        drive(1, 2'b01, 1, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b01, 1, 1, 1, 2'd3, 2'd3, 0, 0, 0);
        drive(1, 2'b01, 1, 1, 0, 2'd3, 2'd0, 1, 0, 0);
        tag = "R11";
        nmi_req = 1; intr_req = 0;
        drive(1, 2'b01, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        nmi_req = 0;
        idle();
        nmi_req = 1;
        drive(1, 2'b00, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        tag = "R13";
        drive(1, 2'b10, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        drive(1, 2'b01, 0, 1, 0, 2'd3, 2'd0, 0, 0, 0);
        idle();

        tag = "R13-rand";
        for (int i = 0; i < 4000; i++) begin
            intr_req = 1'($urandom);
            nmi_req  = 1'($urandom);
            drive(1'($urandom_range(0, 3) != 0), 2'($urandom), ($urandom_range(0, 7) == 0),
                  1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule